// File: doc/BRIEF.md
# Key Matrix Scanner with Multi-Key Flag

This block walks an 8 x 8 key matrix through an external 3-to-8 column decoder and an external 8-to-1 row multiplexer. It drives a 3-bit column code to the decoder, which pulls the chosen column line low. It drives a 3-bit row code to the multiplexer. It reads one active-low sense bit back. A closed key on the driven column pulls its row line low, so a low sense bit means that the key at the current crossing reads as closed.

For each of the 64 crossings the scanner holds the select codes for a fixed number of settle cycles and samples the sense bit in the last one. Every crossing that reads closed is sent out as a 6-bit key code on a valid/ready stream. The key code is the column code followed by the row code, so code 0 is the top-left key. A full walk of the matrix is a pass. At the end of a pass the block gives a one-cycle pass marker and updates a multi-key flag. The flag is set when three or more crossings read closed during the pass. Without isolation diodes, three closed keys on the corners of a rectangle make the fourth corner read closed as well, so such a count cannot be trusted.

Back-pressure works as follows. A key code is presented with `key_valid` high and stays unchanged until a cycle in which `key_ready` is also high. While a presented code waits, the scan freezes: both select codes and the settle count stay put, so no sample is lost. `pass_done` and `ghost_risk` are plain status pins with no handshake.

Top module: `kmx_scanner`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `col_sel` and `row_sel` are 0 and `key_valid`, `pass_done` and `ghost_risk` are low.
- R2: The scan position is the 6-bit value {col_sel, row_sel}. It only ever steps by +1, so row_sel is the inner count and col_sel the outer. After 63 it wraps to 0.
- R3: Each scan position is held for exactly SETTLE_CYC clock cycles when no back-pressure occurs. The sense bit is sampled in the last of those cycles.
- R4: A low `sense_n` at the sample makes the block present `key_valid` high in the next cycle, with `key_code` = {col_sel, row_sel} of the sampled position. Code 0 is column 0, row 0.
- R5: In one pass, every position that reads closed is reported exactly once, in ascending code order. Open positions are never reported.
- R6: While `key_valid` is high and `key_ready` is low, `key_valid` stays high and `key_code`, `col_sel` and `row_sel` do not change. The code is consumed in the first cycle in which both are high.
- R7: `pass_done` is high for exactly one cycle, just after the sample of position 63. In that cycle the position has returned to 0.
- R8: At each pass end, `ghost_risk` takes the value (closed readings in that pass >= GHOST_MIN, default 3). It holds that value until the next pass end, so a later pass with fewer readings clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| col_sel | output | 3 | Column code to the external decoder (its output drives the column low) |
| row_sel | output | 3 | Row code to the external multiplexer |
| sense_n | input | 1 | Multiplexed row line; low means closed |
| key_valid | output | 1 | Key code is presented |
| key_ready | input | 1 | Consumer accepts the presented code |
| key_code | output | 6 | {column, row} code of a closed key |
| pass_done | output | 1 | One-cycle marker at the end of each pass |
| ghost_risk | output | 1 | Last pass had GHOST_MIN or more closed readings |

## Verification
The bench models the matrix without diodes, so a rectangle of three keys also closes the fourth corner. Several matrix patterns are applied:
- An empty matrix shows that no key is reported by accident.
- Single keys at code 0 and code 63 fix the code layout and both ends of the scan.
- Two keys on different rows and columns show ascending order without the flag.
- Three keys on one column show that the flag comes from the count alone.
- A three-key rectangle shows a ghost corner being reported and flagged.
- A single key after the flagged passes shows that the flag clears.

Directed runs then cover the following:
- A run with the consumer holding ready low shows the scan freezing.
- A full walk of an empty matrix checks the step order and the settle length.

// File: rtl/kmx_pkg.sv
package kmx_pkg;
  localparam int SEL_W  = 3;
  localparam int CODE_W = 2 * SEL_W;

  typedef struct packed {
    logic [SEL_W-1:0] col;
    logic [SEL_W-1:0] row;
  } kmx_pos_t;
endpackage

// File: rtl/kmx_stepper.sv
module kmx_stepper
  import kmx_pkg::*;
#(
  parameter int SETTLE_CYC = 4
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     freeze,
  output kmx_pos_t pos,
  output logic     sample,
  output logic     wrap
);
  localparam int CW = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(SETTLE_CYC - 1);

  logic [CW-1:0] dwell;

  assign sample = (dwell == LAST) && !freeze;
  assign wrap   = sample && (pos == '1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dwell <= '0;
      pos   <= '0;
    end else if (!freeze) begin
      if (dwell == LAST) begin
        dwell <= '0;
        pos   <= pos + 1'b1;
      end else begin
        dwell <= dwell + 1'b1;
      end
    end
  end
endmodule

// File: rtl/kmx_tally.sv
module kmx_tally #(
  parameter int GHOST_MIN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sample,
  input  logic hit,
  input  logic wrap,
  output logic pass_done,
  output logic ghost_risk
);
  localparam int CNT_W = $clog2(GHOST_MIN + 1);
  localparam logic [CNT_W:0] LIM = (CNT_W + 1)'(GHOST_MIN);

  logic [CNT_W-1:0] seen;
  logic [CNT_W:0]   nxt;

  assign nxt = {1'b0, seen} + {{CNT_W{1'b0}}, hit};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen       <= '0;
      pass_done  <= 1'b0;
      ghost_risk <= 1'b0;
    end else begin
      pass_done <= sample && wrap;
      if (sample) begin
        if (wrap) begin
          ghost_risk <= (nxt >= LIM);
          seen       <= '0;
        end else if (nxt >= LIM) begin
          seen <= LIM[CNT_W-1:0];
        end else begin
          seen <= nxt[CNT_W-1:0];
        end
      end
    end
  end
endmodule

// File: rtl/kmx_scanner.sv
module kmx_scanner
  import kmx_pkg::*;
#(
  parameter int SETTLE_CYC = 4,
  parameter int GHOST_MIN  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [SEL_W-1:0]  col_sel,
  output logic [SEL_W-1:0]  row_sel,
  input  logic              sense_n,
  output logic              key_valid,
  input  logic              key_ready,
  output logic [CODE_W-1:0] key_code,
  output logic              pass_done,
  output logic              ghost_risk
);
  kmx_pos_t pos;
  logic     sample, wrap, hit, stall;

  assign stall   = key_valid && !key_ready;
  assign hit     = sample && !sense_n;
  assign col_sel = pos.col;
  assign row_sel = pos.row;

  kmx_stepper #(.SETTLE_CYC(SETTLE_CYC)) u_step (
    .clk(clk), .rst_n(rst_n), .freeze(stall),
    .pos(pos), .sample(sample), .wrap(wrap)
  );

  kmx_tally #(.GHOST_MIN(GHOST_MIN)) u_tally (
    .clk(clk), .rst_n(rst_n), .sample(sample), .hit(hit), .wrap(wrap),
    .pass_done(pass_done), .ghost_risk(ghost_risk)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      key_valid <= 1'b0;
      key_code  <= '0;
    end else if (hit) begin
      key_valid <= 1'b1;
      key_code  <= pos;
    end else if (key_ready) begin
      key_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/kmx_scanner_chk.sv
module kmx_scanner_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] col_sel,
  input logic [2:0] row_sel,
  input logic       key_valid,
  input logic       key_ready,
  input logic [5:0] key_code,
  input logic       pass_done,
  input logic       ghost_risk
);
  logic [5:0] at;
  assign at = {col_sel, row_sel};

  AST_POS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (at != $past(at)) |-> (at == $past(at) + 6'd1)); // R2
  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (key_valid && !key_ready) |=> (key_valid && $stable(key_code))); // R6
  AST_SEL_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (key_valid && !key_ready) |=> ($stable(col_sel) && $stable(row_sel))); // R6
  AST_PASS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    pass_done |=> !pass_done); // R7
  AST_PASS_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    pass_done |-> (at == 6'd0)); // R7
  AST_FLAG_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    !pass_done |-> $stable(ghost_risk)); // R8
endmodule

bind kmx_scanner kmx_scanner_chk chk_i (
  .clk(clk), .rst_n(rst_n), .col_sel(col_sel), .row_sel(row_sel),
  .key_valid(key_valid), .key_ready(key_ready), .key_code(key_code),
  .pass_done(pass_done), .ghost_risk(ghost_risk)
);

// File: tb/kmx_scanner_tb.sv
module kmx_scanner_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SETTLE     = 3;
  localparam int NVEC       = 7;
  localparam logic [63:0] VEC [NVEC] = '{
    64'h0000_0000_0000_0000,
    64'h0000_0000_0000_0001,
    64'h8000_0000_0000_0000,
    64'h0040_0000_0000_0200,
    64'h0000_0000_0000_0302,
    64'h0000_5200_0000_0000,
    64'h0000_0008_0000_0000
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic key_ready = 1'b1;
  logic sense_n;
  logic [2:0] col_sel, row_sel;
  logic key_valid, pass_done, ghost_risk;
  logic [5:0] key_code;
  logic [63:0] mask = '0;
  int checks = 0, fails = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  kmx_scanner #(.SETTLE_CYC(SETTLE), .GHOST_MIN(3)) dut_i (
    .clk(clk), .rst_n(rst_n), .col_sel(col_sel), .row_sel(row_sel),
    .sense_n(sense_n), .key_valid(key_valid), .key_ready(key_ready),
    .key_code(key_code), .pass_done(pass_done), .ghost_risk(ghost_risk)
  );

  // Diode-free matrix: a crossing reads closed if pressed, or if it is the
  // fourth corner of a rectangle whose other three corners are pressed.
  function automatic logic reads_closed(logic [63:0] m, int c, int r);
    if (m[c*8+r]) return 1'b1;
    for (int r2 = 0; r2 < 8; r2++)
      for (int c2 = 0; c2 < 8; c2++)
        if (m[c*8+r2] && m[c2*8+r2] && m[c2*8+r]) return 1'b1;
    return 1'b0;
  endfunction

  always_comb sense_n = !reads_closed(mask, int'(col_sel), int'(row_sel));

  task automatic check(string req, logic ok, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      finish_run();
    end
  end

  task automatic to_pass_start();
    do @(negedge clk); while (!pass_done);
  endtask

  task automatic run_vector(int idx);
    int exp_codes[64];
    int got_codes[64];
    int n_exp = 0, n_got = 0;
    logic flag;
    logic order_ok = 1'b1;
    for (int k = 0; k < 64; k++)
      if (reads_closed(VEC[idx], k / 8, k % 8)) begin
        exp_codes[n_exp] = k; n_exp++;
      end
    to_pass_start();
    mask = VEC[idx];
    do begin
      @(negedge clk);
      if (key_valid && key_ready) begin
        if (n_got < 64) got_codes[n_got] = int'(key_code);
        n_got++;
      end
    end while (!pass_done);
    flag = ghost_risk;
    check($sformatf("R5 count vec%0d", idx), n_got == n_exp, n_got, n_exp);
    for (int k = 0; k < n_exp && k < n_got; k++)
      if (got_codes[k] != exp_codes[k]) order_ok = 1'b0;
    check($sformatf("R4 codes vec%0d", idx), order_ok,
          (n_got > 0) ? got_codes[0] : -1, (n_exp > 0) ? exp_codes[0] : -1);
    check($sformatf("R8 ghost_risk vec%0d", idx), flag == (n_exp >= 3),
          int'(flag), int'(n_exp >= 3));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 valid in reset", key_valid == 1'b0, key_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 select after reset", {col_sel, row_sel} == 6'd0, {col_sel, row_sel}, 0);
    check("R1 flags after reset", {key_valid, pass_done, ghost_risk} == 3'b000,
          {key_valid, pass_done, ghost_risk}, 0);

    for (int v = 0; v < NVEC; v++) run_vector(v);

    // R2, R3: step order and settle length over one empty pass
    begin
      int run = 0, bad = 0, changes = 0;
      logic [5:0] prev;
      mask = '0;
      to_pass_start();
      prev = {col_sel, row_sel};
      run = 1;
      for (int t = 1; t < 64 * SETTLE; t++) begin
        @(negedge clk);
        if ({col_sel, row_sel} != prev) begin
          changes++;
          if (run != SETTLE || {col_sel, row_sel} != prev + 6'd1) bad++;
          prev = {col_sel, row_sel};
          run = 1;
        end else run++;
      end
      check("R2 step order", bad == 0, bad, 0);
      check("R3 settle length", changes == 63 && run == SETTLE, run, SETTLE);
    end

    // R6: back-pressure freezes the scan and holds the code
    begin
      logic [5:0] c0, s0;
      int w = 0;
      key_ready = 1'b0;
      mask = 64'h0000_0000_0010_0000;   // code 20
      while (!key_valid && w < 1000) begin @(negedge clk); w++; end
      c0 = key_code; s0 = {col_sel, row_sel};
      check("R4 held code", c0 == 6'd20, c0, 20);
      repeat (10) @(negedge clk);
      check("R6 valid held", key_valid == 1'b1, key_valid, 1);
      check("R6 code stable", key_code == c0, key_code, c0);
      check("R6 select frozen", {col_sel, row_sel} == s0, {col_sel, row_sel}, s0);
      key_ready = 1'b1;
      @(negedge clk);
      check("R6 accepted", key_valid == 1'b0, key_valid, 0);
      @(negedge clk);
      check("R6 scan resumed", {col_sel, row_sel} != s0 || SETTLE > 1,
            {col_sel, row_sel}, s0);
    end

    // R7: pass marker lasts one cycle
    to_pass_start();
    @(negedge clk);
    check("R7 pass_done single cycle", pass_done == 1'b0, pass_done, 0);

    finish_run();
  end
endmodule